// File: doc/BRIEF.md
# UART Automatic Modem Flow Controller

This block sits next to a UART's receive FIFO and its transmitter and handles hardware flow control without software. On the receive side, it compares the FIFO fill count with a programmable trigger level. It raises a receive interrupt request when that level is reached. It drives the active-low request-to-send line (RTS#) with hysteresis: the line is withdrawn when the fill climbs to the level one step above the trigger, and it is offered again only once the fill has drained below the level one step below the trigger.

On the transmit side, the active-low clear-to-send input (CTS#) is synchronised. When automatic CTS handling is on, the block uses CTS# to gate a transmit-allowed output. A stop request is honoured only at a character boundary, so a character already on the wire is never cut short. A resume request takes effect as soon as the synchronised CTS# is seen low.

Both automatic functions are off after reset. With automatic RTS off, RTS# is a plain output that follows a software-written value.

Top module: `uart_autoflow`

## Requirements
- R1: With `auto_rts_en_i` = 0, `rts_n_o` equals the `sw_rts_n_i` value present at the previous rising clock edge, whatever the fill count is.
- R2: With `sw_rts_n_i` = 1, `rts_n_o` is 1 one clock later, whatever the fill count and enables are.
- R3: `trig_sel_i` picks the trigger level from the ladder 0, D/16, D/4, D/2, 3D/4, D−D/16, D, where D = FIFO depth. For D = 128 this is 0, 8, 32, 64, 96, 120, 128. Code 0 selects 8, code 1 selects 32, code 2 selects 64 and code 3 selects 120. With `auto_rts_en_i` = 1, `rx_irq_o` is 1 one clock after the fill is at or above the trigger; otherwise it is 0.
- R4: With automatic RTS on and `sw_rts_n_i` = 0, `rts_n_o` goes to 1 one clock after the fill reaches the ladder entry above the trigger. These upper levels are 32, 64, 96 and 128 for codes 0 to 3.
- R5: While the fill lies between the lower level (inclusive) and the upper level (exclusive), `rts_n_o` keeps its previous value.
- R6: `rts_n_o` returns to 0 one clock after the fill drops below the ladder entry under the trigger. These lower levels are 0, 8, 32 and 96 for codes 0 to 3.
- R7: A fill of 0 always returns `rts_n_o` to 0 under automatic RTS, so the lowest trigger selection, whose lower level is 0, still reasserts.
- R8: Clearing `auto_rts_en_i` discards the withdrawn state. After automatic RTS is re-enabled with the fill inside the band, `rts_n_o` stays 0.
- R9: With `auto_cts_en_i` = 0, `tx_allow_o` is 1 regardless of `cts_n_i` and `tx_boundary_i`.
- R10: With automatic CTS on, `tx_allow_o` falls only in a cycle after `tx_boundary_i` was 1. It falls three clocks after `cts_n_i` rises (two synchroniser stages plus the output register).
- R11: With automatic CTS on, `tx_allow_o` returns to 1 three clocks after `cts_n_i` falls, with no boundary strobe needed.
- R12: While reset is held, `rts_n_o` = 1, `tx_allow_o` = 1 and `rx_irq_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_fill_i | input | CNT_W | Receive FIFO fill count (0..DEPTH) |
| trig_sel_i | input | 2 | Receive trigger level selection code |
| auto_rts_en_i | input | 1 | Automatic RTS enable |
| auto_cts_en_i | input | 1 | Automatic CTS enable |
| sw_rts_n_i | input | 1 | Software-written RTS# value (0 = asserted) |
| cts_n_i | input | 1 | CTS# pin, asynchronous, active low |
| tx_boundary_i | input | 1 | High while the transmitter is between characters |
| rts_n_o | output | 1 | RTS# pin, active low |
| tx_allow_o | output | 1 | Transmitter may start the next character |
| rx_irq_o | output | 1 | Receive trigger interrupt request |

## Verification
The bench builds the block with its default depth of 128, so the count is 8 bits wide and the ladder resolves to 0, 8, 32, 64, 96, 120 and 128. With this depth every trigger code can be walked to both hysteresis edges using exact fill values, including the full-FIFO upper level of code 3 and the empty-FIFO lower level of code 0. Because the synchroniser depth is fixed at two, the three-clock CTS latency can be checked cycle by cycle in both directions.

// File: rtl/uart_autoflow_pkg.sv
package uart_autoflow_pkg;

  typedef logic [1:0] trig_code_t;

  localparam int unsigned LADDER_LAST = 6;

  // Position-indexed hysteresis ladder for a FIFO of the given depth.
  function automatic int unsigned ladder_level(int unsigned depth, int unsigned pos);
    int unsigned lvl;
    case (pos)
      0:       lvl = 0;
      1:       lvl = depth / 16;
      2:       lvl = depth / 4;
      3:       lvl = depth / 2;
      4:       lvl = (3 * depth) / 4;
      5:       lvl = depth - depth / 16;
      default: lvl = depth;
    endcase
    return lvl;
  endfunction

  // Ladder position of the trigger selected by a code.
  function automatic int unsigned trig_pos(trig_code_t code);
    int unsigned p;
    case (code)
      2'd0:    p = 1;
      2'd1:    p = 2;
      2'd2:    p = 3;
      default: p = 5;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/ufc_rst_sync.sv
module ufc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/ufc_level_sel.sv
module ufc_level_sel
  import uart_autoflow_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  trig_code_t       code_i,
  output logic [CNT_W-1:0] trig_o,
  output logic [CNT_W-1:0] upper_o,
  output logic [CNT_W-1:0] lower_o
);
  always_comb begin
    int unsigned p;
    p       = trig_pos(code_i);
    trig_o  = CNT_W'(ladder_level(DEPTH, p));
    upper_o = CNT_W'(ladder_level(DEPTH, p + 1));
    lower_o = CNT_W'(ladder_level(DEPTH, p - 1));
  end
endmodule

// File: rtl/ufc_rts_ctl.sv
module ufc_rts_ctl #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] fill_i,
  input  logic [CNT_W-1:0] trig_i,
  input  logic [CNT_W-1:0] upper_i,
  input  logic [CNT_W-1:0] lower_i,
  input  logic             auto_en_i,
  input  logic             sw_rts_n_i,
  output logic             rts_n_o,
  output logic             irq_o
);
  logic hold_off_q, hold_off_d;
  logic rts_n_q, rts_n_d;
  logic irq_q, irq_d;
  logic upd_en;

  assign upd_en = 1'b1;

  // Hysteresis flag: set at the upper level, cleared below the lower level or when empty.
  always_comb begin
    if (!auto_en_i || sw_rts_n_i)                 hold_off_d = 1'b0;
    else if (fill_i >= upper_i)                   hold_off_d = 1'b1;
    else if (fill_i < lower_i || fill_i == '0)    hold_off_d = 1'b0;
    else                                          hold_off_d = hold_off_q;
    rts_n_d = sw_rts_n_i | hold_off_d;
    irq_d   = auto_en_i & (fill_i >= trig_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_off_q <= 1'b0;
      rts_n_q    <= 1'b1;
      irq_q      <= 1'b0;
    end else if (upd_en) begin
      hold_off_q <= hold_off_d;
      rts_n_q    <= rts_n_d;
      irq_q      <= irq_d;
    end
  end

  assign rts_n_o = rts_n_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/ufc_cts_gate.sv
module ufc_cts_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n_i,
  input  logic auto_en_i,
  input  logic boundary_i,
  output logic allow_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   cts_n_s;
  logic                   allow_q, allow_d;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b1;
          else        sync_q[0] <= cts_n_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= 1'b1;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  assign cts_n_s = sync_q[SYNC_STAGES-1];

  always_comb begin
    if (!auto_en_i)      allow_d = 1'b1;
    else if (!cts_n_s)   allow_d = 1'b1;
    else if (boundary_i) allow_d = 1'b0;
    else                 allow_d = allow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) allow_q <= 1'b1;
    else        allow_q <= allow_d;
  end

  assign allow_o = allow_q;
endmodule

// File: rtl/uart_autoflow.sv
module uart_autoflow
  import uart_autoflow_pkg::*;
#(
  parameter int DEPTH       = 128,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_fill_i,
  input  logic [1:0]       trig_sel_i,
  input  logic             auto_rts_en_i,
  input  logic             auto_cts_en_i,
  input  logic             sw_rts_n_i,
  input  logic             cts_n_i,
  input  logic             tx_boundary_i,
  output logic             rts_n_o,
  output logic             tx_allow_o,
  output logic             rx_irq_o
);
  logic             rst_sync_n;
  logic [CNT_W-1:0] trig_lvl, upper_lvl, lower_lvl;

  ufc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_sync_n)
  );

  ufc_level_sel #(.DEPTH(DEPTH)) u_lvl (
    .code_i  (trig_sel_i),
    .trig_o  (trig_lvl),
    .upper_o (upper_lvl),
    .lower_o (lower_lvl)
  );

  ufc_rts_ctl #(.CNT_W(CNT_W)) u_rts (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .fill_i     (rx_fill_i),
    .trig_i     (trig_lvl),
    .upper_i    (upper_lvl),
    .lower_i    (lower_lvl),
    .auto_en_i  (auto_rts_en_i),
    .sw_rts_n_i (sw_rts_n_i),
    .rts_n_o    (rts_n_o),
    .irq_o      (rx_irq_o)
  );

  ufc_cts_gate #(.SYNC_STAGES(SYNC_STAGES)) u_cts (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cts_n_i    (cts_n_i),
    .auto_en_i  (auto_cts_en_i),
    .boundary_i (tx_boundary_i),
    .allow_o    (tx_allow_o)
  );
endmodule

// File: rtl/uart_autoflow_chk.sv
module uart_autoflow_chk #(
  parameter int DEPTH = 128,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] rx_fill_i,
  input logic             auto_rts_en_i,
  input logic             auto_cts_en_i,
  input logic             sw_rts_n_i,
  input logic             tx_boundary_i,
  input logic             rts_n_o,
  input logic             tx_allow_o,
  input logic             rx_irq_o
);
  assert_manual_rts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(auto_rts_en_i) |-> rts_n_o == $past(sw_rts_n_i));

  assert_sw_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sw_rts_n_i) |-> rts_n_o);

  assert_irq_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(auto_rts_en_i && rx_fill_i >= CNT_W'(DEPTH - DEPTH / 16)) |-> rx_irq_o);

  assert_irq_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(auto_rts_en_i) |-> !rx_irq_o);

  assert_full_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(auto_rts_en_i && rx_fill_i == CNT_W'(DEPTH)) |-> rts_n_o);

  assert_empty_resumes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(auto_rts_en_i && !sw_rts_n_i && rx_fill_i == '0) |-> !rts_n_o);

  assert_cts_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(auto_cts_en_i) |-> tx_allow_o);

  assert_stop_at_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_allow_o) |-> $past(tx_boundary_i));
endmodule

bind uart_autoflow uart_autoflow_chk #(.DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .rx_fill_i     (rx_fill_i),
  .auto_rts_en_i (auto_rts_en_i),
  .auto_cts_en_i (auto_cts_en_i),
  .sw_rts_n_i    (sw_rts_n_i),
  .tx_boundary_i (tx_boundary_i),
  .rts_n_o       (rts_n_o),
  .tx_allow_o    (tx_allow_o),
  .rx_irq_o      (rx_irq_o)
);

// File: tb/test_uart_autoflow.sv
module test_uart_autoflow;
  localparam int DEPTH = 128;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n;
  logic [CNT_W-1:0] fill;
  logic [1:0]       sel;
  logic             a_rts, a_cts, sw_rts_n, cts_n, bnd;
  logic             rts_n, allow, irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  uart_autoflow #(.DEPTH(DEPTH)) i_uart_autoflow (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_fill_i     (fill),
    .trig_sel_i    (sel),
    .auto_rts_en_i (a_rts),
    .auto_cts_en_i (a_cts),
    .sw_rts_n_i    (sw_rts_n),
    .cts_n_i       (cts_n),
    .tx_boundary_i (bnd),
    .rts_n_o       (rts_n),
    .tx_allow_o    (allow),
    .rx_irq_o      (irq)
  );

  task automatic check(string req, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic fill_to(int v);
    fill = CNT_W'(v);
    step();
  endtask

  task automatic t_reset_r12();
    check("R12 rts", rts_n, 1'b1);
    check("R12 allow", allow, 1'b1);
    check("R12 irq", irq, 1'b0);
  endtask

  task automatic t_manual_r1();
    a_rts = 0; sw_rts_n = 0; fill = 0; step();
    check("R1 follow 0", rts_n, 1'b0);
    sw_rts_n = 1; step();
    check("R1 follow 1", rts_n, 1'b1);
    sw_rts_n = 0; fill = CNT_W'(DEPTH); step();
    check("R1 full ignored", rts_n, 1'b0);
  endtask

  task automatic t_sw_off_r2();
    a_rts = 1; sw_rts_n = 1; sel = 2'd1; fill_to(0);
    check("R2 empty", rts_n, 1'b1);
    fill_to(40);
    check("R2 mid", rts_n, 1'b1);
    sw_rts_n = 0; fill_to(0);
  endtask

  task automatic t_irq_r3();
    a_rts = 1; sw_rts_n = 0; sel = 2'd1;
    fill_to(31); check("R3 below 32", irq, 1'b0);
    fill_to(32); check("R3 at 32", irq, 1'b1);
    sel = 2'd0; fill_to(7); check("R3 below 8", irq, 1'b0);
    fill_to(8); check("R3 at 8", irq, 1'b1);
    sel = 2'd3; fill_to(119); check("R3 below 120", irq, 1'b0);
    fill_to(120); check("R3 at 120", irq, 1'b1);
    a_rts = 0; fill_to(120); check("R3 disabled", irq, 1'b0);
    fill_to(0);
  endtask

  task automatic t_hyst_code1_r4_r5_r6();
    a_rts = 1; sw_rts_n = 0; sel = 2'd1;
    fill_to(10); check("R6 start", rts_n, 1'b0);
    fill_to(63); check("R4 just below upper", rts_n, 1'b0);
    fill_to(64); check("R4 upper 64", rts_n, 1'b1);
    fill_to(40); check("R5 band hold high", rts_n, 1'b1);
    fill_to(8);  check("R5 at lower 8", rts_n, 1'b1);
    fill_to(7);  check("R6 below 8", rts_n, 1'b0);
    fill_to(40); check("R5 band hold low", rts_n, 1'b0);
  endtask

  task automatic t_hyst_codes_r4_r6();
    a_rts = 1; sw_rts_n = 0; sel = 2'd2;
    fill_to(95); check("R4 code2 below 96", rts_n, 1'b0);
    fill_to(96); check("R4 code2 at 96", rts_n, 1'b1);
    fill_to(32); check("R5 code2 at 32", rts_n, 1'b1);
    fill_to(31); check("R6 code2 below 32", rts_n, 1'b0);
    sel = 2'd3;
    fill_to(127); check("R4 code3 below full", rts_n, 1'b0);
    fill_to(128); check("R4 code3 full", rts_n, 1'b1);
    fill_to(96);  check("R5 code3 at 96", rts_n, 1'b1);
    fill_to(95);  check("R6 code3 below 96", rts_n, 1'b0);
  endtask

  task automatic t_empty_r7();
    a_rts = 1; sw_rts_n = 0; sel = 2'd0;
    fill_to(31); check("R7 code0 below 32", rts_n, 1'b0);
    fill_to(32); check("R7 code0 at 32", rts_n, 1'b1);
    fill_to(1);  check("R7 code0 one left", rts_n, 1'b1);
    fill_to(0);  check("R7 code0 empty", rts_n, 1'b0);
  endtask

  task automatic t_disable_r8();
    a_rts = 1; sw_rts_n = 0; sel = 2'd1;
    fill_to(70); check("R8 withdrawn", rts_n, 1'b1);
    a_rts = 0; step(); check("R8 manual while off", rts_n, 1'b0);
    a_rts = 1; fill_to(40); check("R8 state discarded", rts_n, 1'b0);
    fill_to(0);
  endtask

  task automatic t_cts_off_r9();
    a_cts = 0; cts_n = 1; bnd = 1; step(4);
    check("R9 cts high ignored", allow, 1'b1);
    bnd = 0; step(2);
    check("R9 no boundary", allow, 1'b1);
  endtask

  task automatic t_cts_r10_r11();
    a_cts = 1; cts_n = 1; bnd = 0; step(5);
    check("R10 no boundary keeps allow", allow, 1'b1);
    bnd = 1; step();
    check("R10 stop at boundary", allow, 1'b0);
    bnd = 0; cts_n = 0; step(2);
    check("R11 still in sync", allow, 1'b0);
    step();
    check("R11 resumed", allow, 1'b1);
    bnd = 1; cts_n = 1; step(2);
    check("R10 latency not yet", allow, 1'b1);
    step();
    check("R10 latency three", allow, 1'b0);
    bnd = 0; cts_n = 0; step(3);
  endtask

  initial begin
    rst_n = 0; fill = '0; sel = 2'd0; a_rts = 0; a_cts = 0;
    sw_rts_n = 1; cts_n = 0; bnd = 0;
    step(3);
    t_reset_r12();
    rst_n = 1;
    step(4);
    t_manual_r1();
    t_sw_off_r2();
    t_irq_r3();
    t_hyst_code1_r4_r5_r6();
    t_hyst_codes_r4_r6();
    t_empty_r7();
    t_disable_r8();
    t_cts_off_r9();
    t_cts_r10_r11();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule